// File: doc/BRIEF.md
# Chunked Conditional-Carry Prefix Adder

This block adds two W-bit operands and a carry-in with a fixed latency that grows with the logarithm of the chunk count, not with the operand width. The operands are cut into N = W/M chunks of M bits. In the first pass every chunk is summed twice in parallel: once as if no carry entered it and once as if one did. The two carry-outs become the chunk's generate and propagate bits, and the no-carry sum is held as a provisional result.

The global carry-in is merged into chunk 0's generate bit. A Kogge-Stone prefix network then resolves the carry entering each chunk above chunk 0. The top chunk's carry-out is not needed inside the network, so that chunk is left out of it. A second pass adds each chunk's resolved carry into its provisional sum. The final carry-out is formed from the top chunk's generate and propagate bits and the carry entering that chunk.

The block is fully pipelined and accepts a new operand pair on every clock. It has no stall path. Results come out in the order the operands went in, flagged by `out_valid`.

Top module: `chunk_prefix_adder`

## Requirements
- R1: When `out_valid` is high, `sum` equals (a + b + c_in) mod 2^W for the operands that were accepted LAT cycles earlier.
- R2: When `out_valid` is high, `c_out` equals bit W of the full sum a + b + c_in for those same operands.
- R3: `out_valid` is high exactly LAT clock edges after the edge that sampled `in_valid` high. LAT = 6 + PLAT, where PLAT = 2 + floor(ceil(log2(N-1))/2) is the prefix network latency. With the defaults W=64 and M=8, LAT is 9.
- R4: Operands presented on consecutive cycles each yield a correct result on consecutive cycles, in input order.
- R5: A clock edge that samples `rst_n` low leaves `out_valid` low in the following cycle.
- R6: A carry-in of 1 applied to an operand pair whose chunks all propagate ripples through every chunk, giving `sum` = 0 and `c_out` = 1.
- R7: A carry generated in chunk 0 reaches the correct chunk across several intermediate chunks that only propagate.
- R8: A cycle with `in_valid` low produces no result: `out_valid` stays low LAT cycles later. The valid operands sent on either side of that cycle still give correct results.
- R9: `c_out` is set when the top chunk generates a carry by itself. It is also set when the top chunk propagates and a carry enters it from below.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous active-low reset; clears the valid pipeline only |
| a | input | W | First operand |
| b | input | W | Second operand |
| c_in | input | 1 | Global carry-in |
| in_valid | input | 1 | Operands on a, b and c_in are to be added |
| sum | output | W | Sum modulo 2^W |
| c_out | output | 1 | Carry-out of the full-width add |
| out_valid | output | 1 | sum and c_out hold a result |

## Verification
The bench drives operands chosen to stress the carry paths, and a cycle-level reference model checks the outputs on every cycle.

- An all-ones operand pair with a carry-in checks that the carry-in is merged into chunk 0 before the prefix network. A design that skipped this would return all ones instead of zero.
- A carry generated in chunk 0 and carried across a run of propagating chunks catches a prefix network with a wrong span or a missing stage. Such a design would drop the carry part-way up.
- Top-chunk generate and propagate cases check the carry-out formula. Getting it wrong shows up as a missing `c_out`, because the top chunk is not part of the network.
- Bubbles in `in_valid` and back-to-back operands expose any misalignment between the delay lines and the prefix latency. A misaligned design would pair a provisional sum with another operand's carry, or assert `out_valid` in the wrong cycle.

// File: rtl/cpa_pkg.sv
// Shared constants and latency arithmetic for the chunked prefix adder.
// Assumes the number of prefix positions is at least 1.
package cpa_pkg;

    // Cycles taken by each chunk-level add pass: input, compute, output registers.
    localparam int CHUNK_LAT = 3;

    // Number of Kogge-Stone levels needed to span the given number of positions.
    function automatic int prefix_levels(input int positions);
        return (positions > 1) ? $clog2(positions) : 0;
    endfunction

    // Prefix latency: input register, one register per pair of levels, output register.
    function automatic int prefix_latency(input int positions);
        return 2 + prefix_levels(positions) / 2;
    endfunction

endpackage

// File: rtl/cpa_chunk_gp.sv
// First-pass chunk adder. Sums one M-bit chunk with carry-in 0 and carry-in 1.
// Outputs the carry-in-0 sum plus the two carry-outs (generate, propagate).
// Three register stages. Data registers carry no reset; only the valid bit does.
module cpa_chunk_gp #(
    parameter int M = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         in_valid,
    input  logic [M-1:0] a,
    input  logic [M-1:0] b,
    output logic [M-1:0] sum0,
    output logic         gen,
    output logic         prop,
    output logic         out_valid
);
    logic [M-1:0] a_q, b_q;
    logic [M-1:0] s_q;
    logic         g_q, p_q;
    logic [2:0]   v_q;
    logic [M:0]   wide0, wide1;

    // Stage 1: capture the operands.
    always_ff @(posedge clk) begin
        a_q <= a;
        b_q <= b;
    end

    // Both carry-in cases come from one add; the +1 case reuses the zero case.
    always_comb begin
        wide0 = {1'b0, a_q} + {1'b0, b_q};
        wide1 = wide0 + {{M{1'b0}}, 1'b1};
    end

    // Stage 2: register the provisional sum and both carry-outs.
    always_ff @(posedge clk) begin
        s_q <= wide0[M-1:0];
        g_q <= wide0[M];
        p_q <= wide1[M];
    end

    // Stage 3: output register.
    always_ff @(posedge clk) begin
        sum0 <= s_q;
        gen  <= g_q;
        prop <= p_q;
    end

    // Valid tracking through the three stages, cleared by reset.
    always_ff @(posedge clk) begin
        if (!rst_n) v_q <= '0;
        else        v_q <= {v_q[1:0], in_valid};
    end

    assign out_valid = v_q[2];

endmodule

// File: rtl/cpa_chunk_inc.sv
// Second-pass chunk adder. Adds a single resolved carry bit into a provisional
// M-bit sum. The carry-out is dropped: the prefix network has already
// accounted for any overflow of this chunk. Three register stages; only the
// valid bit is reset.
module cpa_chunk_inc #(
    parameter int M = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         in_valid,
    input  logic [M-1:0] a,
    input  logic         cin,
    output logic [M-1:0] sum,
    output logic         out_valid
);
    logic [M-1:0] a_q, s_q;
    logic         c_q;
    logic [2:0]   v_q;

    // Stage 1: capture the provisional sum and its carry.
    always_ff @(posedge clk) begin
        a_q <= a;
        c_q <= cin;
    end

    // Stage 2: add the carry.
    always_ff @(posedge clk) begin
        s_q <= a_q + {{(M-1){1'b0}}, c_q};
    end

    // Stage 3: output register.
    always_ff @(posedge clk) begin
        sum <= s_q;
    end

    // Valid tracking, cleared by reset.
    always_ff @(posedge clk) begin
        if (!rst_n) v_q <= '0;
        else        v_q <= {v_q[1:0], in_valid};
    end

    assign out_valid = v_q[2];

endmodule

// File: rtl/cpa_prefix.sv
// Kogge-Stone carry network over P positions. The inputs are already
// registered here. A register follows level k (0-based) when k is even and
// it is not the last level. The result is registered again on the way out.
// Assumes the generate at position 0 already includes the global carry-in, so
// the group generate at position i is the carry leaving position i.
// Latency equals cpa_pkg::prefix_latency(P).
module cpa_prefix #(
    parameter int P = 7
) (
    input  logic         clk,
    input  logic [P-1:0] gen_in,
    input  logic [P-1:0] prop_in,
    output logic [P-1:0] carry_out
);
    localparam int LEVELS = cpa_pkg::prefix_levels(P);

    logic [P-1:0] g_q, p_q, g_last;

    // Input register: isolates the network from the first-pass outputs.
    always_ff @(posedge clk) begin
        g_q <= gen_in;
        p_q <= prop_in;
    end

    for (genvar k = 0; k < LEVELS; k++) begin : stg
        localparam int SPAN    = 1 << k;
        localparam bit REG_OUT = ((k % 2) == 0) && (k + 1 < LEVELS);
        logic [P-1:0] g_src, p_src, g_cmb, g_out;

        if (k == 0) begin : src_first
            assign g_src = g_q;
            assign p_src = p_q;
        end else begin : src_prev
            assign g_src = stg[k-1].g_out;
            assign p_src = stg[k-1].pn.p_out;
        end

        // Group generate: fold in the generate from SPAN positions below.
        always_comb begin
            for (int i = 0; i < P; i++) begin
                if (i >= SPAN) g_cmb[i] = g_src[i] | (p_src[i] & g_src[i-SPAN]);
                else           g_cmb[i] = g_src[i];
            end
        end

        if (REG_OUT) begin : g_reg
            // Pipeline register after this level.
            always_ff @(posedge clk) g_out <= g_cmb;
        end else begin : g_wire
            assign g_out = g_cmb;
        end

        if (k + 1 < LEVELS) begin : pn
            logic [P-1:0] p_cmb, p_out;
            // Group propagate, needed only by later levels.
            always_comb begin
                for (int i = 0; i < P; i++) begin
                    if (i >= SPAN) p_cmb[i] = p_src[i] & p_src[i-SPAN];
                    else           p_cmb[i] = p_src[i];
                end
            end
            if (REG_OUT) begin : p_reg
                // Pipeline register after this level.
                always_ff @(posedge clk) p_out <= p_cmb;
            end else begin : p_wire
                assign p_out = p_cmb;
            end
        end
    end

    if (LEVELS == 0) begin : last_none
        assign g_last = g_q;
    end else begin : last_lvl
        assign g_last = stg[LEVELS-1].g_out;
    end

    // Output register.
    always_ff @(posedge clk) begin
        carry_out <= g_last;
    end

endmodule

// File: rtl/chunk_prefix_adder.sv
// W-bit adder built from N = W/M chunks: a conditional first pass, a
// Kogge-Stone carry network and a carry-insert second pass.
// Fixed latency 6 + prefix latency; one operand pair accepted per cycle.
// Assumes W is a multiple of M and N >= 2. Data registers are reset-free;
// the valid pipeline uses a synchronous active-low reset.
module chunk_prefix_adder #(
    parameter int W = 64,
    parameter int M = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    input  logic         c_in,
    input  logic         in_valid,
    output logic [W-1:0] sum,
    output logic         c_out,
    output logic         out_valid
);
    localparam int N    = W / M;
    localparam int P    = N - 1;
    localparam int CL   = cpa_pkg::CHUNK_LAT;
    localparam int PLAT = cpa_pkg::prefix_latency(P);

    logic [N-1:0]  g1, p1, v1, v3;
    logic [W-1:0]  s1;
    logic [CL-1:0] cin_pipe;
    logic          cin_l1;
    logic [P-1:0]  g_fold, c_vec;
    logic [N-1:0]  carry3;
    logic          cout_f;
    logic [CL-1:0] cout_pipe;

    logic [W-1:0]  s_dl   [PLAT];
    logic          gt_dl  [PLAT];
    logic          pt_dl  [PLAT];
    logic          cin_dl [PLAT];
    logic [PLAT-1:0] v_dl;

    // First pass: conditional sums per chunk.
    for (genvar i = 0; i < N; i++) begin : gp
        cpa_chunk_gp #(.M(M)) u_gp (
            .clk       (clk),
            .rst_n     (rst_n),
            .in_valid  (in_valid),
            .a         (a[i*M +: M]),
            .b         (b[i*M +: M]),
            .sum0      (s1[i*M +: M]),
            .gen       (g1[i]),
            .prop      (p1[i]),
            .out_valid (v1[i])
        );
    end

    // Delay the global carry-in to line up with the first-pass results.
    always_ff @(posedge clk) begin
        cin_pipe <= {cin_pipe[CL-2:0], c_in};
    end
    assign cin_l1 = cin_pipe[CL-1];

    // Fold the carry-in into chunk 0 so network carries are absolute.
    always_comb begin
        g_fold    = g1[P-1:0];
        g_fold[0] = g1[0] | (p1[0] & cin_l1);
    end

    cpa_prefix #(.P(P)) u_pfx (
        .clk       (clk),
        .gen_in    (g_fold),
        .prop_in   (p1[P-1:0]),
        .carry_out (c_vec)
    );

    // Reset-free delay lines matching the prefix latency.
    always_ff @(posedge clk) begin
        s_dl[0]   <= s1;
        gt_dl[0]  <= g1[N-1];
        pt_dl[0]  <= p1[N-1];
        cin_dl[0] <= cin_l1;
        for (int d = 1; d < PLAT; d++) begin
            s_dl[d]   <= s_dl[d-1];
            gt_dl[d]  <= gt_dl[d-1];
            pt_dl[d]  <= pt_dl[d-1];
            cin_dl[d] <= cin_dl[d-1];
        end
    end

    // Valid delay line across the prefix stage, cleared by reset.
    always_ff @(posedge clk) begin
        if (!rst_n) v_dl <= '0;
        else if (PLAT > 1) v_dl <= {v_dl[PLAT-2:0], &v1};
        else               v_dl <= {{(PLAT-1){1'b0}}, &v1};
    end

    assign carry3 = {c_vec, cin_dl[PLAT-1]};

    // Second pass: add the resolved carry into each provisional sum.
    for (genvar i = 0; i < N; i++) begin : inc
        cpa_chunk_inc #(.M(M)) u_inc (
            .clk       (clk),
            .rst_n     (rst_n),
            .in_valid  (v_dl[PLAT-1]),
            .a         (s_dl[PLAT-1][i*M +: M]),
            .cin       (carry3[i]),
            .sum       (sum[i*M +: M]),
            .out_valid (v3[i])
        );
    end

    // Carry-out from the top chunk, then delayed to match the second pass.
    assign cout_f = gt_dl[PLAT-1] | (pt_dl[PLAT-1] & c_vec[P-1]);

    always_ff @(posedge clk) begin
        cout_pipe <= {cout_pipe[CL-2:0], cout_f};
    end

    assign c_out     = cout_pipe[CL-1];
    assign out_valid = &v3;

endmodule

// File: rtl/chunk_prefix_adder_chk.sv
// Property checker for chunk_prefix_adder. Keeps its own delayed copy of the
// expected full-width sum and of in_valid, LAT stages deep, and compares them
// with the ports.
module chunk_prefix_adder_chk #(
    parameter int W = 64,
    parameter int M = 8
) (
    input logic         clk,
    input logic         rst_n,
    input logic [W-1:0] a,
    input logic [W-1:0] b,
    input logic         c_in,
    input logic         in_valid,
    input logic [W-1:0] sum,
    input logic         c_out,
    input logic         out_valid
);
    localparam int LAT = 2 * cpa_pkg::CHUNK_LAT + cpa_pkg::prefix_latency(W / M - 1);

    logic [W:0]     exp_pipe [LAT];
    logic [LAT-1:0] v_pipe;

    // Expected full sum, carried alongside the design.
    always_ff @(posedge clk) begin
        exp_pipe[0] <= {1'b0, a} + {1'b0, b} + {{W{1'b0}}, c_in};
        for (int d = 1; d < LAT; d++) exp_pipe[d] <= exp_pipe[d-1];
    end

    // Valid reference with reset.
    always_ff @(posedge clk) begin
        if (!rst_n) v_pipe <= '0;
        else        v_pipe <= {v_pipe[LAT-2:0], in_valid};
    end

    assert_sum_R1: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> (sum == exp_pipe[LAT-1][W-1:0]));

    assert_cout_R2: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> (c_out == exp_pipe[LAT-1][W]));

    assert_latency_R3: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid == v_pipe[LAT-1]);

    assert_reset_R5: assert property (@(posedge clk)
        !rst_n |=> !out_valid);

endmodule

bind chunk_prefix_adder chunk_prefix_adder_chk #(.W(W), .M(M)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .a         (a),
    .b         (b),
    .c_in      (c_in),
    .in_valid  (in_valid),
    .sum       (sum),
    .c_out     (c_out),
    .out_valid (out_valid)
);

// File: tb/sim_chunk_prefix_adder.sv
// Bench for chunk_prefix_adder: a behavioural queue model compared every cycle.
module sim_chunk_prefix_adder;
    localparam int W   = 64;
    localparam int M   = 8;
    localparam int N   = W / M;
    localparam int LAT = 3 + (2 + $clog2(N - 1) / 2) + 3;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic [W-1:0] a = '0, b = '0;
    logic         c_in = 1'b0, in_valid = 1'b0;
    logic [W-1:0] sum;
    logic         c_out, out_valid;

    int checks = 0;
    int failures = 0;
    int cyc = 0;
    bit done = 0;

    bit       qv [$];
    logic [W:0] qs [$];
    string    qt [$];

    chunk_prefix_adder #(.W(W), .M(M)) u0 (
        .clk(clk), .rst_n(rst_n), .a(a), .b(b), .c_in(c_in),
        .in_valid(in_valid), .sum(sum), .c_out(c_out), .out_valid(out_valid)
    );

    always #5 clk = ~clk;

    // Watchdog: a hung run counts as a failure and still reports.
    always @(posedge clk) begin
        cyc++;
        if (cyc > 100000 && !done) begin
            failures++;
            $display("FAIL watchdog expired actual=%0d expected<=%0d", cyc, 100000);
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    // One cycle: check the result due now, then drive and record new operands.
    task automatic step(input bit v, input logic [W-1:0] ta, input logic [W-1:0] tb,
                        input bit tc, input string tag);
        bit ev;
        logic [W:0] es;
        string et;
        @(negedge clk);
        if (qv.size() == LAT) begin
            ev = qv.pop_front();
            es = qs.pop_front();
            et = qt.pop_front();
            checks++;
            if (out_valid !== ev) begin
                failures++;
                $display("FAIL R3 (%s) out_valid actual=%0b expected=%0b", et, out_valid, ev);
            end
            if (ev) begin
                checks++;
                if (sum !== es[W-1:0]) begin
                    failures++;
                    $display("FAIL R1 (%s) sum actual=%h expected=%h", et, sum, es[W-1:0]);
                end
                checks++;
                if (c_out !== es[W]) begin
                    failures++;
                    $display("FAIL R2 (%s) c_out actual=%0b expected=%0b", et, c_out, es[W]);
                end
            end
        end
        in_valid = v;
        a = ta;
        b = tb;
        c_in = tc;
        qv.push_back(v);
        qs.push_back({1'b0, ta} + {1'b0, tb} + {{W{1'b0}}, tc});
        qt.push_back(tag);
    endtask

    function automatic logic [W-1:0] rnd();
        return {$urandom, $urandom};
    endfunction

    initial begin
        // Reset phase: invalid inputs recorded, so out_valid is expected low.
        for (int i = 0; i < 4; i++) step(1'b0, '0, '0, 1'b0, "R5");
        checks++;
        if (out_valid !== 1'b0) begin
            failures++;
            $display("FAIL R5 out_valid in reset actual=%0b expected=0", out_valid);
        end
        @(negedge clk);
        rst_n = 1'b1;
        qv.push_back(1'b0); qs.push_back('0); qt.push_back("R5");

        // R4: back-to-back random operands.
        for (int i = 0; i < 150; i++) step(1'b1, rnd(), rnd(), 1'($urandom), "R4");

        // R6: carry-in ripples through every chunk.
        step(1'b1, {W{1'b1}}, '0, 1'b1, "R6");
        step(1'b1, {W{1'b1}}, {W{1'b1}}, 1'b1, "R6");
        step(1'b1, {W{1'b1}}, '0, 1'b0, "R6");
        step(1'b1, {{(W-M){1'b0}}, {M{1'b1}}}, '0, 1'b1, "R6");

        // R7: carry generated in chunk 0 crosses propagating chunks.
        step(1'b1, {{M{1'b0}}, {(W-2*M){1'b1}}, 8'h80}, {{(W-M){1'b0}}, 8'h80}, 1'b0, "R7");
        step(1'b1, {{(W/2){1'b0}}, {(W/2-M){1'b1}}, 8'hC0}, {{(W-M){1'b0}}, 8'h40}, 1'b0, "R7");
        step(1'b1, {{(W-3*M){1'b1}}, {(2*M){1'b0}}, 8'hFF}, {{(W-M){1'b0}}, 8'h01}, 1'b0, "R7");

        // R9: top chunk generates alone, or propagates a carry from below.
        step(1'b1, {8'hFF, {(W-M){1'b0}}}, {8'h01, {(W-M){1'b0}}}, 1'b0, "R9");
        step(1'b1, {W{1'b1}}, {{(W-1){1'b0}}, 1'b1}, 1'b0, "R9");
        step(1'b1, {8'hFF, {(W-M){1'b0}}}, {(W){1'b0}}, 1'b1, "R9");
        step(1'b1, {8'hFE, {(W-M){1'b1}}}, {8'h01, {(W-M){1'b0}}}, 1'b1, "R9");

        // R8: bubbles between valid operands.
        for (int i = 0; i < 60; i++) step(1'(i % 3 != 1), rnd(), rnd(), 1'($urandom), "R8");

        // Drain.
        for (int i = 0; i < LAT + 2; i++) step(1'b0, '0, '0, 1'b0, "R8");

        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule